// File: doc/BRIEF.md
# Rate-Limited Cached ADC Reader

This block sits in front of a slow analog-to-digital converter that is driven through byte commands. A client asks for the value of one of a small set of logical channels. The block keeps the last sample of each channel together with a refresh deadline. It runs a real conversion only when the channel has no sample yet, when its deadline has expired against a free-running tick count, or when the client forces a scan. In every other case it answers from its cache in one cycle.

A conversion sends one command byte to the converter and then takes two response bytes from it, which together form a 10-bit result. The result is stored along with a new deadline, set to the completion tick plus two fifths of the tick rate, so that a channel refreshes at most five times every two seconds. The bus that carries the bytes is outside the block. The block serves one request at a time.

Top module: `adc_cache_reader`

## Requirements
- R1: A read of a channel that has held no sample since reset always starts a conversion.
- R2: A conversion raises cmd_valid for exactly one cycle with cmd_byte = {converter channel, 1'b1}. With the default map, logical channels 0, 1, 2 and 3 use converter channels 2, 0, 5 and 6.
- R3: The result is {first response byte, second response byte bits [1:0]}. Bits [7:2] of the second byte have no effect on it.
- R4: A read that needs no conversion raises ready on the cycle after the request and returns the cached value. It issues no command.
- R5: When a conversion completes at tick T, the channel deadline becomes T + REFRESH, where REFRESH = TICK_RATE*2/5 (40 by default). A later read converts only when the tick is strictly later than the deadline.
- R6: A forced scan always converts, whatever the deadline.
- R7: The deadline comparison is wrap-safe. A deadline that has wrapped past zero still holds off reads until the tick passes it.
- R8: A request that arrives while a conversion is in progress is ignored. It produces no command and no ready.
- R9: ready is a one-cycle strobe. value changes only together with ready.
- R10: After reset, ready and cmd_valid are low and value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | TICK_W | Free-running tick count |
| req_valid | input | 1 | Read request strobe |
| req_force | input | 1 | With req_valid: force a conversion |
| req_chan | input | CH_IDX_W | Logical channel of the request |
| cmd_valid | output | 1 | Command byte strobe to the converter |
| cmd_byte | output | 8 | Command byte |
| rsp_valid | input | 1 | Response byte strobe from the converter |
| rsp_byte | input | 8 | Response byte (high part first, then low part) |
| ready | output | 1 | Result strobe |
| value | output | 10 | Result value |

## Verification
The hardest cases to reach are the deadline edges: the read exactly at the deadline, one tick past it, and a deadline that has wrapped through zero. Because the tick is an input, the bench jumps it straight to those values instead of waiting. It forces a conversion at 0xFFF0, then reads at 0x0010, 0x0018 and 0x0019. A second hard case is a request that lands while the block waits for a response byte. The bench places one there, between the command and the first response byte, and counts commands and strobes.

// File: rtl/adc_cache_pkg.sv
package adc_cache_pkg;
   localparam int CONV_CH_W = 7;
   localparam int RESULT_W  = 10;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_CMD    = 2'd1,
      SEQ_RSP_HI = 2'd2,
      SEQ_RSP_LO = 2'd3
   } seq_state_t;

   function automatic logic [7:0] build_cmd(input logic [CONV_CH_W-1:0] conv_ch);
      return {conv_ch, 1'b1};
   endfunction

   function automatic logic [RESULT_W-1:0] join_result(input logic [7:0] hi,
                                                       input logic [1:0] lo);
      return {hi, lo};
   endfunction
endpackage

// File: rtl/adc_chan_store.sv
module adc_chan_store #(
   parameter int NUM_CH   = 4,
   parameter int TICK_W   = 16,
   parameter int VAL_W    = 10,
   localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [TICK_W-1:0] rd_deadline,
   output logic              rd_valid,
   output logic [VAL_W-1:0]  rd_data,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TICK_W-1:0] wr_deadline,
   input  logic [VAL_W-1:0]  wr_data
);
   logic [TICK_W-1:0] dl_q   [NUM_CH];
   logic [VAL_W-1:0]  data_q [NUM_CH];
   logic [NUM_CH-1:0] vld_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dl_q[g]   <= '0;
            data_q[g] <= '0;
            vld_q[g]  <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            dl_q[g]   <= wr_deadline;
            data_q[g] <= wr_data;
            vld_q[g]  <= 1'b1;
         end else if (clr_en && clr_idx == IDX_W'(g)) begin
            dl_q[g]   <= '0;
         end
      end
   end

   always_comb begin
      rd_deadline = '0;
      rd_data     = '0;
      rd_valid    = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_deadline = dl_q[i];
            rd_data     = data_q[i];
            rd_valid    = vld_q[i];
         end
      end
   end
endmodule

// File: rtl/adc_deadline_cmp.sv
module adc_deadline_cmp #(
   parameter int TICK_W    = 16,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] deadline,
   output logic              passed
);
   if (WRAP_SAFE) begin : g_wrap
      logic [TICK_W-1:0] diff;
      always_comb begin
         diff   = tick - deadline;
         passed = !diff[TICK_W-1] && (diff != '0);
      end
   end else begin : g_plain
      always_comb passed = (tick > deadline);
   end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_cache_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int TICK_W  = 16,
   parameter int REFRESH = 40,
   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TICK_W-1:0]    tick,
   input  logic                 req_valid,
   input  logic                 req_force,
   input  logic [IDX_W-1:0]     req_chan,
   input  logic                 dl_passed,
   input  logic                 rd_valid,
   input  logic [RESULT_W-1:0]  rd_data,
   input  logic [CONV_CH_W-1:0] conv_num,
   output logic [IDX_W-1:0]     cur_chan,
   output logic                 busy,
   output logic                 cmd_valid,
   output logic [7:0]           cmd_byte,
   input  logic                 rsp_valid,
   input  logic [7:0]           rsp_byte,
   output logic                 ready,
   output logic [RESULT_W-1:0]  value,
   output logic                 clr_en,
   output logic                 wr_en,
   output logic [TICK_W-1:0]    wr_deadline,
   output logic [RESULT_W-1:0]  wr_data
);
   seq_state_t       state_q;
   logic [7:0]       hi_q;
   logic             need_conv;

   always_comb begin
      busy        = (state_q != SEQ_IDLE);
      need_conv   = req_force || !rd_valid || dl_passed;
      cmd_valid   = (state_q == SEQ_CMD);
      cmd_byte    = build_cmd(conv_num);
      clr_en      = !busy && req_valid && req_force;
      wr_en       = (state_q == SEQ_RSP_LO) && rsp_valid;
      wr_data     = join_result(hi_q, rsp_byte[1:0]);
      wr_deadline = tick + TICK_W'(REFRESH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         hi_q     <= '0;
         cur_chan <= '0;
         ready    <= 1'b0;
         value    <= '0;
      end else begin
         ready <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  cur_chan <= req_chan;
                  if (need_conv) begin
                     state_q <= SEQ_CMD;
                  end else begin
                     ready <= 1'b1;
                     value <= rd_data;
                  end
               end
            end
            SEQ_CMD: state_q <= SEQ_RSP_HI;
            SEQ_RSP_HI: begin
               if (rsp_valid) begin
                  hi_q    <= rsp_byte;
                  state_q <= SEQ_RSP_LO;
               end
            end
            SEQ_RSP_LO: begin
               if (rsp_valid) begin
                  ready   <= 1'b1;
                  value   <= wr_data;
                  state_q <= SEQ_IDLE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_cache_reader.sv
module adc_cache_reader
   import adc_cache_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int TICK_W    = 16,
   parameter int TICK_RATE = 100,
   parameter bit WRAP_SAFE = 1'b1,
   parameter logic [NUM_CH*CONV_CH_W-1:0] CH_MAP = {7'd6, 7'd5, 7'd0, 7'd2},
   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int REFRESH  = TICK_RATE * 2 / 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TICK_W-1:0]   tick,
   input  logic                req_valid,
   input  logic                req_force,
   input  logic [CH_IDX_W-1:0] req_chan,
   output logic                cmd_valid,
   output logic [7:0]          cmd_byte,
   input  logic                rsp_valid,
   input  logic [7:0]          rsp_byte,
   output logic                ready,
   output logic [RESULT_W-1:0] value
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (TICK_W < 8) begin : g_bad_tick
      $error("TICK_W must be at least 8");
   end
   if (REFRESH < 1 || REFRESH >= (2 ** (TICK_W - 1))) begin : g_bad_refresh
      $error("REFRESH must be positive and below half the tick range");
   end

   logic [CH_IDX_W-1:0]  cur_chan;
   logic [CH_IDX_W-1:0]  rd_idx;
   logic                 busy;
   logic [TICK_W-1:0]    rd_deadline;
   logic                 rd_valid;
   logic [RESULT_W-1:0]  rd_data;
   logic                 dl_passed;
   logic [CONV_CH_W-1:0] conv_num;
   logic                 clr_en;
   logic                 wr_en;
   logic [TICK_W-1:0]    wr_deadline;
   logic [RESULT_W-1:0]  wr_data;

   always_comb begin
      rd_idx   = busy ? cur_chan : req_chan;
      conv_num = CH_MAP[cur_chan*CONV_CH_W +: CONV_CH_W];
   end

   adc_chan_store #(.NUM_CH(NUM_CH), .TICK_W(TICK_W), .VAL_W(RESULT_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_deadline(rd_deadline), .rd_valid(rd_valid), .rd_data(rd_data),
      .clr_en(clr_en), .clr_idx(req_chan),
      .wr_en(wr_en), .wr_idx(cur_chan), .wr_deadline(wr_deadline), .wr_data(wr_data)
   );

   adc_deadline_cmp #(.TICK_W(TICK_W), .WRAP_SAFE(WRAP_SAFE)) i_cmp (
      .tick(tick), .deadline(rd_deadline), .passed(dl_passed)
   );

   adc_conv_seq #(.NUM_CH(NUM_CH), .TICK_W(TICK_W), .REFRESH(REFRESH)) i_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req_valid(req_valid), .req_force(req_force), .req_chan(req_chan),
      .dl_passed(dl_passed), .rd_valid(rd_valid), .rd_data(rd_data),
      .conv_num(conv_num), .cur_chan(cur_chan), .busy(busy),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
      .ready(ready), .value(value),
      .clr_en(clr_en), .wr_en(wr_en), .wr_deadline(wr_deadline), .wr_data(wr_data)
   );
endmodule

// File: rtl/adc_cache_reader_chk.sv
module adc_cache_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       busy,
   input logic       ready,
   input logic       cmd_valid,
   input logic [7:0] cmd_byte,
   input logic [9:0] value
);
   AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R2
   AST_CMD_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_byte[0]); // R2
   AST_IDLE_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (ready || cmd_valid)); // R4
   AST_NO_STRAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> !ready); // R8
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready); // R9
   AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !$past(ready)) |-> $stable(value)); // R9
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && cmd_valid)); // R8
endmodule

bind adc_cache_reader adc_cache_reader_chk i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .ready(ready), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .value(value)
);

// File: tb/test_adc_cache_reader.sv
module test_adc_cache_reader;
   localparam int CLK_PERIOD = 10;
   localparam int REFRESH    = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tick = '0;
   logic        req_valid = 1'b0;
   logic        req_force = 1'b0;
   logic [1:0]  req_chan = '0;
   logic        cmd_valid;
   logic [7:0]  cmd_byte;
   logic        rsp_valid = 1'b0;
   logic [7:0]  rsp_byte = '0;
   logic        ready;
   logic [9:0]  value;

   int checks = 0;
   int errors = 0;
   int seq_n  = 0;
   bit finished = 0;

   logic [9:0]  m_val [4];
   logic [15:0] m_dl  [4];
   bit          m_vld [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_cache_reader i_adc_cache_reader (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req_valid(req_valid), .req_force(req_force), .req_chan(req_chan),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
      .ready(ready), .value(value)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic logic [6:0] conv_of(input int ch);
      case (ch)
         0: return 7'd2;
         1: return 7'd0;
         2: return 7'd5;
         default: return 7'd6;
      endcase
   endfunction

   // one request; inject places a second request while busy (R8)
   task automatic transact(input int ch, input bit frc, input bit inject, input string rq);
      bit          exp_conv, conv, done;
      logic [7:0]  b0, b1, cseen;
      logic [15:0] diff;
      logic [9:0]  exp_v, got;
      int          lat, cmds, readies;
      diff     = tick - m_dl[ch];
      exp_conv = frc || !m_vld[ch] || (!diff[15] && diff != 0);
      b0 = 8'((seq_n * 37 + 11) & 255);
      b1 = 8'((seq_n * 91 + 164) & 255);
      seq_n++;
      exp_v = exp_conv ? {b0, b1[1:0]} : m_val[ch];
      conv = 0; done = 0; lat = 1; cmds = 0; readies = 0; cseen = '0; got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_force = frc; req_chan = 2'(ch);
      @(negedge clk);
      req_valid = 1'b0; req_force = 1'b0;
      for (int k = 0; k < 40 && !done; k++) begin
         if (ready) begin
            readies++; got = value; done = 1;
         end else if (cmd_valid) begin
            cmds++; conv = 1; cseen = cmd_byte;
            @(negedge clk);
            if (cmd_valid) cmds++;
            if (inject) begin req_valid = 1'b1; req_chan = 2'(ch ^ 1); end
            @(negedge clk);
            req_valid = 1'b0;
            if (cmd_valid) cmds++;
            rsp_valid = 1'b1; rsp_byte = b0;
            @(negedge clk);
            rsp_valid = 1'b0;
            if (cmd_valid || ready) cmds++;
            @(negedge clk);
            rsp_valid = 1'b1; rsp_byte = b1;
            @(negedge clk);
            rsp_valid = 1'b0;
         end else begin
            @(negedge clk);
            lat++;
         end
      end
      chk(done, {rq, " ready seen"}, done, 1);
      chk(conv == exp_conv, {rq, " conversion decision R5"}, conv, exp_conv);
      chk(got == exp_v, {rq, " value R3"}, got, exp_v);
      if (exp_conv) begin
         chk(cseen == {conv_of(ch), 1'b1}, {rq, " command byte R2"}, cseen, {conv_of(ch), 1'b1});
         chk(cmds == 1, {rq, " single command R2 R8"}, cmds, 1);
         m_val[ch] = exp_v; m_dl[ch] = tick + 16'(REFRESH); m_vld[ch] = 1;
      end else begin
         chk(lat == 1, {rq, " hit latency R4"}, lat, 1);
      end
      @(negedge clk);
      chk(!ready && !cmd_valid, {rq, " strobe one cycle R9"}, ready, 0);
      chk(value == exp_v, {rq, " value held R9"}, value, exp_v);
      if (inject) begin
         // the ignored request left nothing behind: idle, no command
         repeat (3) @(negedge clk);
         chk(!ready && !cmd_valid, {rq, " busy request ignored R8"}, cmd_valid, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin m_val[i] = '0; m_dl[i] = '0; m_vld[i] = 0; end
      repeat (3) @(negedge clk);
      chk(!ready && !cmd_valid && value == 0, "R10 reset state", value, 0);
      rst_n = 1'b1;
      tick = 16'd100;
      for (int c = 0; c < 4; c++) transact(c, 0, 0, "R1 first read");
      for (int c = 0; c < 4; c++) transact(c, 0, 0, "R4 cached reread");
      tick = 16'd140;
      transact(0, 0, 0, "R5 at deadline");
      tick = 16'd141;
      transact(0, 0, 0, "R5 past deadline");
      transact(2, 1, 0, "R6 forced scan");
      transact(2, 1, 0, "R6 forced again");
      tick = 16'hFFF0;
      transact(1, 1, 0, "R7 force before wrap");
      tick = 16'h0010;
      transact(1, 0, 0, "R7 wrapped hold");
      tick = 16'h0018;
      transact(1, 0, 0, "R7 wrapped deadline");
      tick = 16'h0019;
      transact(1, 0, 0, "R7 wrapped expiry");
      transact(3, 1, 1, "R8 request while busy");
      for (int s = 0; s < 40; s++) begin
         tick = tick + 16'(s * 7 + 3);
         transact(s % 4, (s % 9) == 5, 0, "R3 R5 sweep");
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            chk(0, "watchdog", 0, 1);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule